// File: doc/BRIEF.md
# Halt-Driven Clock Enable Controller

This block decides, every cycle of the free-running clock, which of three gated clock domains may run: the main gated domain, the SoC-interface domain and the reset-crossing domain. It turns the main and SoC-interface clocks off only when gating has been enabled by software and the processor reports that it is halted. Even then, a wake event brings every gated domain back, and a bus select brings back the SoC-interface domain alone, for as long as the select stays high.

The reset-crossing domain does not follow the halt state at all. It behaves like a free-running clock that pauses only while a reset event is present. All three enables are flops clocked by the ungated clock, so a downstream clock-gate cell or a testbench sees clean, glitch-free levels. The clock-gate cells themselves sit outside this block.

Top module: `ckg_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it, all three enables are 1 and the gating bit is 0.
- R2: The gating bit takes `cfg_wdata` on a rising edge where `cfg_we` is 1 and otherwise holds its value. Enable decisions made on later edges use the new value.
- R3: When the gating bit is 0 or `core_halted` is 0, `en_main` and `en_soc` are 1, whatever `apb_sel` and `wake_evt` are.
- R4: When gating is on, the core is halted, and `wake_evt` and `apb_sel` are both 0, `en_main` and `en_soc` are 0.
- R5: When gating is on, the core is halted and `wake_evt` is 0, a high `apb_sel` sets `en_soc` to 1 and leaves `en_main` at 0. `en_soc` returns to 0 one edge after `apb_sel` falls.
- R6: When gating is on and the core is halted, a high `wake_evt` sets `en_main` and `en_soc` to 1 for as long as it stays high.
- R7: `en_rdc` is 0 exactly on the cycles that follow an edge where `rst_evt` was 1, and is 1 otherwise. It ignores the gating bit and `core_halted`.
- R8: Each enable is registered. It changes only at a rising edge of `clk`, one edge after the inputs that cause the change.
- R9: `rst_evt` has no effect on `en_main` or `en_soc`.
- R10: `en_main` is never 1 while `en_soc` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Ungated free-running clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the gating bit |
| cfg_wdata | input | 1 | Value written to the gating bit |
| core_halted | input | 1 | Processor halt status |
| apb_sel | input | 1 | Peripheral bus select toward the SoC interface |
| wake_evt | input | 1 | Wake condition |
| rst_evt | input | 1 | Reset event for the reset-crossing domain |
| en_main | output | 1 | Enable for the main gated clock |
| en_rdc | output | 1 | Enable for the reset-crossing clock |
| en_soc | output | 1 | Enable for the SoC-interface clock |

## Verification
The gating bit is internal, so if it is set or cleared wrongly, the error appears only as enables that differ from expectation one edge after a halted cycle. The bench therefore compares every enable on every cycle. If the policy mixes up domains, for example a bus select that wakes the main clock, or halt status that leaks into the reset-crossing enable, the port shows the wrong value on the very next edge. Checking the outputs just before each edge exposes any enable that changes outside a clock edge.

// File: rtl/ckg_pkg.sv
package ckg_pkg;

    typedef struct packed {
        logic main;
        logic rdc;
        logic soc;
    } ckg_en_t;

    localparam int CKG_NUM_DOM = $bits(ckg_en_t);
    localparam ckg_en_t CKG_ALL_ON = '{main: 1'b1, rdc: 1'b1, soc: 1'b1};

    typedef struct packed {
        logic halted;
        logic psel;
        logic wake;
        logic rst_evt;
    } ckg_req_t;

    // Next-cycle enable policy for the three gated domains.
    function automatic ckg_en_t ckg_policy(logic gate_on, ckg_req_t req);
        ckg_en_t r;
        logic    quiet;
        quiet  = gate_on & req.halted;
        r.main = ~quiet | req.wake;
        r.soc  = ~quiet | req.wake | req.psel;
        r.rdc  = ~req.rst_evt;
        return r;
    endfunction

endpackage

// File: rtl/ckg_cfg_reg.sv
module ckg_cfg_reg #(
    parameter logic RESET_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic we,
    input  logic wdata,
    output logic gate_on
);
    always_ff @(posedge clk) begin
        if (rst)     gate_on <= RESET_VAL;
        else if (we) gate_on <= wdata;
    end

    // R2
    gate_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(gate_on));
endmodule

// File: rtl/ckg_policy_eval.sv
module ckg_policy_eval
    import ckg_pkg::*;
(
    input  logic     gate_on,
    input  ckg_req_t req,
    output ckg_en_t  nxt
);
    always_comb nxt = ckg_policy(gate_on, req);
endmodule

// File: rtl/ckg_en_regs.sv
module ckg_en_regs #(
    parameter int            NUM  = 3,
    parameter logic [NUM-1:0] INIT = '1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NUM-1:0] d,
    output logic [NUM-1:0] q
);
    for (genvar i = 0; i < NUM; i++) begin : g_dom
        always_ff @(posedge clk) begin
            if (rst) q[i] <= INIT[i];
            else     q[i] <= d[i];
        end
    end
endmodule

// File: rtl/ckg_ctrl.sv
module ckg_ctrl
    import ckg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cfg_we,
    input  logic cfg_wdata,
    input  logic core_halted,
    input  logic apb_sel,
    input  logic wake_evt,
    input  logic rst_evt,
    output logic en_main,
    output logic en_rdc,
    output logic en_soc
);
    logic     gate_on;
    ckg_req_t req;
    ckg_en_t  nxt;
    ckg_en_t  cur;

    assign req = '{halted: core_halted, psel: apb_sel, wake: wake_evt, rst_evt: rst_evt};

    ckg_cfg_reg #(.RESET_VAL(1'b0)) u_cfg (
        .clk(clk), .rst(rst), .we(cfg_we), .wdata(cfg_wdata), .gate_on(gate_on)
    );

    ckg_policy_eval u_eval (.gate_on(gate_on), .req(req), .nxt(nxt));

    ckg_en_regs #(.NUM(CKG_NUM_DOM), .INIT(CKG_ALL_ON)) u_regs (
        .clk(clk), .rst(rst), .d(nxt), .q(cur)
    );

    assign en_main = cur.main;
    assign en_rdc  = cur.rdc;
    assign en_soc  = cur.soc;

    // R3
    awake_on_chk: assert property (@(posedge clk) disable iff (rst)
        (!gate_on || !core_halted) |=> (en_main && en_soc));
    // R4
    quiet_off_chk: assert property (@(posedge clk) disable iff (rst)
        (gate_on && core_halted && !wake_evt && !apb_sel) |=> (!en_main && !en_soc));
    // R5
    psel_soc_only_chk: assert property (@(posedge clk) disable iff (rst)
        (gate_on && core_halted && !wake_evt && apb_sel) |=> (en_soc && !en_main));
    // R6
    wake_all_chk: assert property (@(posedge clk) disable iff (rst)
        wake_evt |=> (en_main && en_soc));
    // R7
    rdc_off_chk: assert property (@(posedge clk) disable iff (rst)
        rst_evt |=> !en_rdc);
    // R7
    rdc_on_chk: assert property (@(posedge clk) disable iff (rst)
        !rst_evt |=> en_rdc);
    // R10
    main_needs_soc_chk: assert property (@(posedge clk) disable iff (rst)
        en_main |-> en_soc);
endmodule

// File: tb/tb_ckg_ctrl.sv
module tb_ckg_ctrl;
    logic clk = 1'b0;
    logic rst, cfg_we, cfg_wdata, core_halted, apb_sel, wake_evt, rst_evt;
    logic en_main, en_rdc, en_soc;
    int   total = 0;
    int   bad = 0;
    logic model_gate;
    logic [2:0] exp_en;

    always #4 clk = ~clk;

    ckg_ctrl dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .core_halted(core_halted), .apb_sel(apb_sel), .wake_evt(wake_evt),
        .rst_evt(rst_evt), .en_main(en_main), .en_rdc(en_rdc), .en_soc(en_soc)
    );

    // Expected {main, rdc, soc} from the requirements.
    function automatic logic [2:0] expect_en(logic g, logic h, logic p, logic w, logic r);
        logic off_state;
        off_state = g && h;
        return {(!off_state || w), !r, (!off_state || w || p)};
    endfunction

    task automatic check(string req, logic [2:0] act, logic [2:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%b exp=%b (main,rdc,soc)", req, act, exp);
        end
    endtask

    // Drive one cycle, check no early change (R8), then check the result.
    task automatic step(string req, logic we, logic wd, logic h, logic p, logic w, logic r);
        logic [2:0] nxt;
        @(negedge clk);
        cfg_we = we; cfg_wdata = wd; core_halted = h;
        apb_sel = p; wake_evt = w; rst_evt = r;
        nxt = expect_en(model_gate, h, p, w, r);
        #1;
        check("R8", {en_main, en_rdc, en_soc}, exp_en);
        @(posedge clk);
        #2;
        if (we) model_gate = wd;
        exp_en = nxt;
        check(req, {en_main, en_rdc, en_soc}, exp_en);
    endtask

    initial begin
        #1_000_000;
        bad++;
        total++;
        $display("FAIL watchdog act=hung exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1; cfg_we = 1; cfg_wdata = 1; core_halted = 1;
        apb_sel = 0; wake_evt = 0; rst_evt = 0;
        repeat (3) @(posedge clk);
        #2;
        check("R1", {en_main, en_rdc, en_soc}, 3'b111);
        @(negedge clk);
        rst = 0; cfg_we = 0;
        model_gate = 0;
        exp_en = 3'b111;
        // R1: gating bit still clear after reset despite the write attempt
        step("R1", 0, 0, 1, 0, 0, 0);
        step("R3", 0, 0, 1, 1, 1, 0);
        // R2: enable gating, then halt with nothing active
        step("R2", 1, 1, 0, 0, 0, 0);
        step("R3", 0, 0, 0, 0, 0, 0);
        step("R4", 0, 0, 1, 0, 0, 0);
        step("R4", 0, 0, 1, 0, 0, 0);
        step("R5", 0, 0, 1, 1, 0, 0);
        step("R5", 0, 0, 1, 1, 0, 0);
        step("R5", 0, 0, 1, 0, 0, 0);
        step("R6", 0, 0, 1, 0, 1, 0);
        step("R6", 0, 0, 1, 1, 1, 0);
        step("R4", 0, 0, 1, 0, 0, 0);
        step("R7", 0, 0, 1, 0, 0, 1);
        step("R9", 0, 0, 1, 0, 0, 1);
        step("R7", 0, 0, 0, 0, 0, 0);
        step("R9", 0, 0, 0, 1, 0, 1);
        step("R7", 0, 0, 1, 0, 0, 0);
        // R2: clear gating while halted
        step("R2", 1, 0, 1, 0, 0, 0);
        step("R2", 0, 0, 1, 0, 0, 0);
        for (int i = 0; i < 3000; i++) begin
            logic [6:0] rv;
            rv = 7'($urandom);
            step("R10", (rv[6:3] == 4'd0), rv[0], rv[1] | rv[4], rv[2] & rv[5],
                 rv[3] & rv[4] & rv[5], rv[6] & rv[2]);
            if (en_main && !en_soc) check("R10", {en_main, en_soc}, 2'b01);
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule